// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps wall-clock time and calendar date as a chain of packed BCD fields: seconds, minutes, hours (24-hour), day of week, date, month and a two-digit year. A one-cycle tick input, normally produced once per second by a prescaler outside the block, advances the seconds. Each rollover carries into the next field within the same clock cycle. The day of week runs on its own from 1 to 7 and steps at every midnight, without reference to the date.

The length of each month comes from the current month and year fields. February has 29 days whenever the two-digit year is a multiple of four. This rule is wrong for a century year such as 2100. Software sets the time with a single load strobe that writes every field at once. A stop input freezes the count while software reads or prepares a new setting.

No data stream crosses this block's edge. The load port is a plain strobe with no valid/ready handshake. It is never back-pressured: a load is always accepted in the cycle it is presented. All outputs are registered and show the current fields at all times.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00:00:00, day of week 1, date 01, month 01, year 00.
- R2: Seconds count 00 to 59 in BCD. A tick at 59 gives 00 and advances minutes on the same clock edge.
- R3: Minutes count 00 to 59. The wrap from 59 to 00 advances hours on the same edge.
- R4: Hours count 00 to 23. The wrap from 23 to 00 advances both the date and the day of week on the same edge.
- R5: Day of week counts 1 to 7 and wraps from 7 to 1 at midnight, independent of the date.
- R6: The last date is 31 for months 01, 03, 05, 07, 08, 10 and 12. It is 30 for months 04, 06, 09 and 11. Past the last date, the date returns to 01 and the month advances.
- R7: In month 02 the last date is 29 when the BCD year, read as a decimal number, is divisible by four (00 included). Otherwise it is 28.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: A load strobe writes all seven fields in one cycle. It wins over a tick in the same cycle, and it works while stop is high. Values that are not valid BCD are stored unchanged.
- R10: While stop is high, ticks have no effect and every field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle advance-by-one-second pulse |
| stop_i | input | 1 | Freeze: ticks ignored while high |
| load_i | input | 1 | Write all load fields this cycle |
| ld_sec_i | input | 8 | BCD seconds to load |
| ld_min_i | input | 8 | BCD minutes to load |
| ld_hour_i | input | 8 | BCD hours to load |
| ld_dow_i | input | 3 | Day of week to load (1..7) |
| ld_date_i | input | 8 | BCD date to load |
| ld_mon_i | input | 8 | BCD month to load |
| ld_year_i | input | 8 | BCD two-digit year to load |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| dow_o | output | 3 | Day of week |
| date_o | output | 8 | BCD date |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The bench ticks through one full day and compares every second against a count computed from the elapsed seconds. A carry that lagged one cycle, or a binary rather than decimal digit step, would break this comparison at the first :09 or :59. For every year 00 to 99 and every month, it loads the last date at 23:59:59 and ticks once. A wrong month table or leap test would then show 29, 31 or 32 instead of 01, or a month that does not advance. It also sweeps the day of week through 7-to-1, checks that a load wins over a simultaneous tick, and checks that stop freezes the fields and that invalid BCD is kept.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BCD_W = 8;

  // Add one to a two-digit packed BCD value.
  function automatic logic [BCD_W-1:0] bcd_step(input logic [BCD_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Two-digit BCD year divisible by four.
  function automatic logic bcd_leap(input logic [BCD_W-1:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter logic [BCD_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BCD_W-1:0] load_val_i,
  input  logic             inc_i,
  input  logic [BCD_W-1:0] lo_i,
  input  logic [BCD_W-1:0] hi_i,
  output logic [BCD_W-1:0] q_o,
  output logic             carry_o
);
  logic at_top;
  assign at_top  = (q_o == hi_i);
  assign carry_o = inc_i && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= RST_VAL;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= at_top ? lo_i : bcd_step(q_o);
  end

  // R2 R3 R6 R8: a field at its top value returns to its bottom value
  p_field_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && q_o == hi_i) |=> (q_o == $past(lo_i)));

  // R10: no increment and no load keeps the field
  p_field_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(q_o));
endmodule

// File: rtl/cal_dow.sv
module cal_dow #(
  parameter int DAYS = 7,
  localparam int W = $clog2(DAYS + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(DAYS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= W'(1);
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= (q_o == LAST) ? W'(1) : q_o + W'(1);
  end

  // R5: last day of week wraps to the first
  p_dow_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && q_o == LAST) |=> (q_o == W'(1)));
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [BCD_W-1:0] mon_i,
  input  logic [BCD_W-1:0] year_i,
  output logic [BCD_W-1:0] last_o
);
  always_comb begin
    unique case (mon_i)
      8'h02:                      last_o = bcd_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       stop_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [2:0] ld_dow_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [2:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  logic adv;
  logic c_sec, c_min, c_hour, c_date, c_mon, c_year;
  logic [BCD_W-1:0] last_date;

  // R9 R10: load wins, stop blocks ticks
  assign adv = tick_i && !stop_i && !load_i;

  cal_bcd_field #(.RST_VAL(8'h00)) u_sec (
    .clk, .rst_n, .load_i, .load_val_i(ld_sec_i), .inc_i(adv),
    .lo_i(8'h00), .hi_i(8'h59), .q_o(sec_o), .carry_o(c_sec));

  cal_bcd_field #(.RST_VAL(8'h00)) u_min (
    .clk, .rst_n, .load_i, .load_val_i(ld_min_i), .inc_i(c_sec),
    .lo_i(8'h00), .hi_i(8'h59), .q_o(min_o), .carry_o(c_min));

  cal_bcd_field #(.RST_VAL(8'h00)) u_hour (
    .clk, .rst_n, .load_i, .load_val_i(ld_hour_i), .inc_i(c_min),
    .lo_i(8'h00), .hi_i(8'h23), .q_o(hour_o), .carry_o(c_hour));

  cal_dow #(.DAYS(7)) u_dow (
    .clk, .rst_n, .load_i, .load_val_i(ld_dow_i), .inc_i(c_hour), .q_o(dow_o));

  cal_month_len u_len (.mon_i(mon_o), .year_i(year_o), .last_o(last_date));

  cal_bcd_field #(.RST_VAL(8'h01)) u_date (
    .clk, .rst_n, .load_i, .load_val_i(ld_date_i), .inc_i(c_hour),
    .lo_i(8'h01), .hi_i(last_date), .q_o(date_o), .carry_o(c_date));

  cal_bcd_field #(.RST_VAL(8'h01)) u_mon (
    .clk, .rst_n, .load_i, .load_val_i(ld_mon_i), .inc_i(c_date),
    .lo_i(8'h01), .hi_i(8'h12), .q_o(mon_o), .carry_o(c_mon));

  cal_bcd_field #(.RST_VAL(8'h00)) u_year (
    .clk, .rst_n, .load_i, .load_val_i(ld_year_i), .inc_i(c_mon),
    .lo_i(8'h00), .hi_i(8'h99), .q_o(year_o), .carry_o(c_year));

  // R9: a load places every field in the next cycle
  p_load_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sec_o == $past(ld_sec_i) && min_o == $past(ld_min_i) &&
                hour_o == $past(ld_hour_i) && dow_o == $past(ld_dow_i) &&
                date_o == $past(ld_date_i) && mon_o == $past(ld_mon_i) &&
                year_o == $past(ld_year_i)));

  // R10: stop without load freezes everything
  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                             $stable(dow_o) && $stable(date_o) && $stable(mon_o) &&
                             $stable(year_o)));

  // R4: midnight clears the time and steps the day of week
  p_midnight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 && dow_o == 3'd3)
    |=> (sec_o == 8'h00 && min_o == 8'h00 && hour_o == 8'h00 && dow_o == 3'd4));

  // R8: New Year rollover of a valid year 99
  p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mon && year_o == 8'h99) |=> (year_o == 8'h00 && !c_year));
endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, stop_i = 1'b0, load_i = 1'b0;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_date_i = '0, ld_mon_i = '0, ld_year_i = '0;
  logic [2:0] ld_dow_i = '0;
  logic [7:0] sec_o, min_o, hour_o, date_o, mon_o, year_o;
  logic [2:0] dow_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar u0 (.*);

  function automatic logic [7:0] bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [50:0] snap();
    return {sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o};
  endfunction

  function automatic logic [50:0] pack(input int s, input int mi, input int h,
                                       input int d, input int dt, input int mo, input int y);
    return {bcd(s), bcd(mi), bcd(h), 3'(d), bcd(dt), bcd(mo), bcd(y)};
  endfunction

  task automatic chk(input string tag, input logic [50:0] act, input logic [50:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [2:0] d, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] y, input logic with_tick);
    ld_sec_i = s; ld_min_i = mi; ld_hour_i = h; ld_dow_i = d;
    ld_date_i = dt; ld_mon_i = mo; ld_year_i = y;
    load_i = 1'b1; tick_i = with_tick;
    @(negedge clk);
    load_i = 1'b0; tick_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", snap(), pack(0, 0, 0, 1, 1, 1, 0));

    // R2 R3 R4: one whole day of ticks, modelled from elapsed seconds
    for (int t = 1; t <= 86400; t++) begin
      do_tick();
      chk("R2 R3 R4 day sweep", snap(),
          pack(t % 60, (t / 60) % 60, (t / 3600) % 24, 1 + (t / 86400) % 7, 1 + t / 86400, 1, 0));
    end

    // R5: day of week wraps independently of the date
    for (int d = 1; d <= 7; d++) begin
      do_load(8'h59, 8'h59, 8'h23, 3'(d), 8'h15, 8'h06, 8'h10, 1'b0);
      do_tick();
      chk("R5 dow step", snap(), pack(0, 0, 0, (d == 7) ? 1 : d + 1, 16, 6, 10));
    end

    // R6 R7 R8: last date of every month of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        do_load(8'h59, 8'h59, 8'h23, 3'd2, bcd(mlen(m, y)), bcd(m), bcd(y), 1'b0);
        do_tick();
        chk((m == 2) ? "R7 leap month end" : ((m == 12) ? "R8 year end" : "R6 month end"),
            snap(), pack(0, 0, 0, 3, 1, (m == 12) ? 1 : m + 1, (m == 12) ? (y + 1) % 100 : y));
      end
    end

    // R7: February 28 in a leap year goes to 29
    do_load(8'h59, 8'h59, 8'h23, 3'd1, 8'h28, 8'h02, 8'h48, 1'b0);
    do_tick();
    chk("R7 feb 28 leap", snap(), pack(0, 0, 0, 2, 29, 2, 48));

    // R9: load wins over a same-cycle tick
    do_load(8'h30, 8'h12, 8'h07, 3'd5, 8'h09, 8'h03, 8'h21, 1'b1);
    chk("R9 load over tick", snap(), pack(30, 12, 7, 5, 9, 3, 21));

    // R10: stop freezes the fields
    stop_i = 1'b1;
    repeat (5) do_tick();
    chk("R10 stop hold", snap(), pack(30, 12, 7, 5, 9, 3, 21));

    // R9: load while stopped, invalid BCD kept
    do_load(8'h5A, 8'h7F, 8'h3C, 3'd0, 8'h00, 8'h1F, 8'hAB, 1'b1);
    chk("R9 load invalid while stopped", snap(),
        {8'h5A, 8'h7F, 8'h3C, 3'd0, 8'h00, 8'h1F, 8'hAB});
    stop_i = 1'b0;

    // R2: ticking resumes after stop drops
    do_load(8'h08, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h00, 1'b0);
    do_tick();
    chk("R2 digit step after stop", snap(), pack(9, 0, 0, 1, 1, 1, 0));
    do_tick();
    chk("R2 tens carry", snap(), pack(10, 0, 0, 1, 1, 1, 0));

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule